// File: doc/BRIEF.md
# Eight-bit timer/counter with shared prescaler

The block is an 8-bit counting peripheral for a small controller. It counts either the instruction-cycle tick, which the block derives as one pulse every `CLK_PER_ICYC` system clocks, or edges on an external pin. The pin passes through a two-stage synchroniser and an edge detector, and the counting edge can be selected. A single power-of-two prescaler sits either in front of the count register or behind an externally supplied watchdog tick, and an assignment bit picks which side it serves. When the count rolls from FFh to 00h it sets a sticky overflow flag, and an enable bit gates that flag onto the interrupt line.

Software reaches the block through a small register bus with three addresses: the count, an option register and a flag/enable register. Read data is registered. Writing the count blocks counting for the next two instruction cycles. While the sleep input is high, the count register does not advance.

Top module: `ctr8_unit`

## Requirements
- R1: After a synchronous reset the count, the option register, the flag and the enable read 0, and `irq_o` and `wdt_tick_o` are low.
- R2: Address 0 is the count (read/write). Address 1 is the option register: bits 5:0 are written and read back, and bits 7:6 read 0. Address 2 holds the flag in bit 0 and the enable in bit 1, both read/write. `bus_rdata_o` shows the register addressed in the previous cycle.
- R3: Option fields: bit 0 selects the source (0 = instruction tick, 1 = external pin). Bit 1 selects the edge (0 = rising, 1 = falling). Bit 2 assigns the prescaler (0 = timer, 1 = watchdog). Bits 5:3 are the rate.
- R4: In timer mode with the prescaler assigned to the watchdog, the count rises by one per instruction cycle of 4 clocks.
- R5: The first two instruction-cycle boundaries after a count write are discarded, together with any source events that arrive before the second of them. A count written at X and read 4·K+1 clocks later at 1:1 therefore shows X+K−2.
- R6: An external pin transition is synchronised by two flops. The count changes on the third rising clock edge after the pin changes.
- R7: In counter mode only the selected edge of the pin increments the count.
- R8: With the prescaler assigned to the timer, the count advances once per 2^(rate+1) source events. A count write or an option write clears the prescaler.
- R9: With the prescaler assigned to the watchdog, `wdt_tick_o` pulses once per 2^rate pulses of `wd_tick_i`. Otherwise each `wd_tick_i` pulse is copied to `wdt_tick_o`. In both cases the output is one clock later.
- R10: A rollover from FFh to 00h sets the flag. The flag is cleared only by writing 0 to bit 0 of address 2, and a rollover in the same cycle as that write wins.
- R11: `irq_o` equals flag AND enable, in the same cycle as the register values.
- R12: While `sleep_i` is high the count does not increment, but bus writes still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Halts counting while high |
| ext_pin_i | input | 1 | Asynchronous external count input |
| wd_tick_i | input | 1 | One-clock pulse from the watchdog time base |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Overflow interrupt request |
| wdt_tick_o | output | 1 | Watchdog tick after optional prescaling |

## Verification
The bench writes the count, waits a whole number of instruction cycles and reads back exactly X+K−2. A design that drops the post-write hold reads two counts high, and one that holds for the wrong number of cycles is also off by a fixed amount. External-pin tests end on an unmatched edge, so a design that ignores edge select is off by one. A latency probe reads the count one cycle before and after the synchronised edge, which exposes a synchroniser of the wrong depth. Overflow, flag stickiness, the gating by the enable bit, and the prescaler in both assignments (including a count that misses the power-of-two ratio, or a missing clear) are each measured against counts derived from the requirements.

// File: rtl/ctr8_pkg.sv
package ctr8_pkg;
  localparam int RATE_W = 3;

  typedef enum logic [1:0] {
    RA_COUNT  = 2'd0,
    RA_OPTION = 2'd1,
    RA_CTRL   = 2'd2
  } reg_addr_e;

  // Packed from MSB to LSB: rate[5:3], to_wdt[2], fall_edge[1], ext_src[0]
  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              to_wdt;
    logic              fall_edge;
    logic              ext_src;
  } opt_t;

  localparam int OPT_W = $bits(opt_t);
endpackage

// File: rtl/ctr8_edge_sync.sv
module ctr8_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic fall_i,
  output logic evt_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      for (int i = STAGES-1; i > 0; i--) sync_q[i] <= sync_q[i-1];
      sync_q[0] <= pin_i;
      last_q    <= sync_q[STAGES-1];
    end
  end

  // One-clock event on the chosen transition of the synchronised pin
  assign evt_o = fall_i ? (last_q & ~sync_q[STAGES-1])
                        : (~last_q & sync_q[STAGES-1]);
endmodule

// File: rtl/ctr8_prescaler.sv
module ctr8_prescaler #(
  parameter int W    = 8,
  parameter int SH_W = $clog2(W+1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            evt_i,
  input  logic [SH_W-1:0] shift_i,
  output logic            out_o
);
  localparam logic [W:0] ONE = (W+1)'(1);

  logic [W-1:0] cnt_q;
  logic [W:0]   span;
  logic [W-1:0] mask;

  assign span  = (ONE << shift_i) - ONE;
  assign mask  = span[W-1:0];
  assign out_o = evt_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (evt_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ctr8_core.sv
module ctr8_core #(
  parameter int CNT_W        = 8,
  parameter int INHIB_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             icyc_i,
  input  logic             inc_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             ctrl_wr_i,
  input  logic             flag_wdata_i,
  input  logic             en_wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic             busy_o,
  output logic             flag_o,
  output logic             en_o,
  output logic             irq_o
);
  localparam int IW = $clog2(INHIB_CYCLES+1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [IW-1:0] hold_q;
  logic          flag_n, en_n;

  assign busy_o = cnt_wr_i || (hold_q != '0);

  always_ff @(posedge clk) begin
    if (rst)                          hold_q <= '0;
    else if (cnt_wr_i)                hold_q <= IW'(INHIB_CYCLES);
    else if (icyc_i && hold_q != '0)  hold_q <= hold_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           count_o <= '0;
    else if (cnt_wr_i) count_o <= cnt_wdata_i;
    else if (inc_i)    count_o <= count_o + 1'b1;
  end

  always_comb begin
    flag_n = flag_o;
    if (ctrl_wr_i) flag_n = flag_wdata_i;
    if (inc_i && !cnt_wr_i && count_o == CNT_MAX) flag_n = 1'b1;
    en_n = ctrl_wr_i ? en_wdata_i : en_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      en_o   <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_o <= flag_n;
      en_o   <= en_n;
      irq_o  <= flag_n & en_n;
    end
  end
endmodule

// File: rtl/ctr8_unit.sv
module ctr8_unit
  import ctr8_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int CLK_PER_ICYC = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int INHIB_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_i,
  input  logic             ext_pin_i,
  input  logic             wd_tick_i,
  input  logic             bus_we_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o,
  output logic             irq_o,
  output logic             wdt_tick_o
);
  localparam int PH_W = (CLK_PER_ICYC > 1) ? $clog2(CLK_PER_ICYC) : 1;
  localparam int SH_W = $clog2(CNT_W+1);

  opt_t             opt_q;
  logic [PH_W-1:0]  ph_q;
  logic             icyc, ext_evt, src_evt, tmr_evt, busy;
  logic             pre_in, pre_out, pre_clr, inc;
  logic [SH_W-1:0]  pre_shift;
  logic             cnt_wr, opt_wr, ctrl_wr;
  logic [CNT_W-1:0] cnt_val;
  logic             flag_val, en_val;

  assign cnt_wr  = bus_we_i && (bus_addr_i == RA_COUNT);
  assign opt_wr  = bus_we_i && (bus_addr_i == RA_OPTION);
  assign ctrl_wr = bus_we_i && (bus_addr_i == RA_CTRL);

  // Instruction-cycle tick
  assign icyc = (ph_q == PH_W'(CLK_PER_ICYC-1));
  always_ff @(posedge clk) begin
    if (rst || icyc) ph_q <= '0;
    else             ph_q <= ph_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         opt_q <= '0;
    else if (opt_wr) opt_q <= opt_t'(bus_wdata_i[OPT_W-1:0]);
  end

  ctr8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(ext_pin_i),
    .fall_i(opt_q.fall_edge), .evt_o(ext_evt)
  );

  assign src_evt = opt_q.ext_src ? ext_evt : icyc;
  assign tmr_evt = src_evt && !sleep_i && !busy;

  // One prescaler, routed to one side
  assign pre_in    = opt_q.to_wdt ? wd_tick_i : tmr_evt;
  assign pre_clr   = opt_wr || (cnt_wr && !opt_q.to_wdt);
  assign pre_shift = opt_q.to_wdt ? SH_W'(opt_q.rate)
                                  : SH_W'(opt_q.rate) + SH_W'(1);

  ctr8_prescaler #(.W(CNT_W), .SH_W(SH_W)) u_pre (
    .clk(clk), .rst(rst), .clr_i(pre_clr), .evt_i(pre_in),
    .shift_i(pre_shift), .out_o(pre_out)
  );

  assign inc = opt_q.to_wdt ? tmr_evt : pre_out;

  ctr8_core #(.CNT_W(CNT_W), .INHIB_CYCLES(INHIB_CYCLES)) u_core (
    .clk(clk), .rst(rst), .icyc_i(icyc), .inc_i(inc),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(bus_wdata_i),
    .ctrl_wr_i(ctrl_wr), .flag_wdata_i(bus_wdata_i[0]), .en_wdata_i(bus_wdata_i[1]),
    .count_o(cnt_val), .busy_o(busy), .flag_o(flag_val), .en_o(en_val),
    .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) wdt_tick_o <= 1'b0;
    else     wdt_tick_o <= opt_q.to_wdt ? pre_out : wd_tick_i;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata_o <= '0;
    else begin
      case (bus_addr_i)
        RA_COUNT:  bus_rdata_o <= cnt_val;
        RA_OPTION: bus_rdata_o <= {{(CNT_W-OPT_W){1'b0}}, opt_q};
        RA_CTRL:   bus_rdata_o <= {{(CNT_W-2){1'b0}}, en_val, flag_val};
        default:   bus_rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ctr8_unit_chk.sv
module ctr8_unit_chk
  import ctr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sleep_i,
  input logic             wd_tick_i,
  input logic             bus_we_i,
  input logic [1:0]       bus_addr_i,
  input logic [CNT_W-1:0] bus_wdata_i,
  input logic             irq_o,
  input logic             wdt_tick_o,
  input logic [CNT_W-1:0] count,
  input logic             flag,
  input logic             en,
  input logic             to_wdt
);
  logic cnt_wr;
  assign cnt_wr = bus_we_i && (bus_addr_i == RA_COUNT);

  a_r2_count_write: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnt_wr)) |-> (count == $past(bus_wdata_i)));

  a_r5_hold_after_write: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(cnt_wr, 2) && !$past(cnt_wr)) |-> $stable(count));

  a_r9_passthrough: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(to_wdt)) |-> (wdt_tick_o == $past(wd_tick_i)));

  a_r10_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cnt_wr) && $past(count) == {CNT_W{1'b1}} && count == '0) |-> flag);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(flag)) |->
      ($past(bus_we_i) && $past(bus_addr_i) == RA_CTRL && !$past(bus_wdata_i[0])));

  a_r11_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq_o == (flag && en));

  a_r12_sleep_freeze: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sleep_i) && !$past(cnt_wr)) |-> $stable(count));
endmodule

bind ctr8_unit ctr8_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sleep_i(sleep_i), .wd_tick_i(wd_tick_i),
  .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
  .irq_o(irq_o), .wdt_tick_o(wdt_tick_o), .count(cnt_val),
  .flag(flag_val), .en(en_val), .to_wdt(opt_q.to_wdt)
);

// File: tb/ctr8_unit_tb_top.sv
module ctr8_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep_i = 1'b0, ext_pin_i = 1'b0, wd_tick_i = 1'b0;
  logic       bus_we_i = 1'b0;
  logic [1:0] bus_addr_i = 2'd0;
  logic [7:0] bus_wdata_i = 8'h00;
  logic [7:0] bus_rdata_o;
  logic       irq_o, wdt_tick_o;

  int n_checks = 0;
  int n_err    = 0;
  int wdt_seen = 0;
  logic wdt_cnt_en = 1'b0, wdt_clr = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sb_q[$];
  event sample_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctr8_unit dut_i (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .ext_pin_i(ext_pin_i),
    .wd_tick_i(wd_tick_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .irq_o(irq_o), .wdt_tick_o(wdt_tick_o)
  );

  task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // Monitor side of the scoreboard
  initial begin
    forever begin
      @(sample_ev);
      if (sb_q.size() != 0) begin
        exp_t it;
        it = sb_q.pop_front();
        chk8(bus_rdata_o, it.exp, it.tag);
      end
    end
  end

  always @(negedge clk) begin
    if (wdt_clr)                       wdt_seen = 0;
    else if (wdt_cnt_en && wdt_tick_o) wdt_seen++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // Driver side
  task automatic expect_rd(input logic [7:0] e, input string tag);
    sb_q.push_back('{e, tag});
    -> sample_ev;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk); bus_we_i = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); bus_addr_i = a;
    @(negedge clk); expect_rd(e, tag);
  endtask

  // Call right after a count write: K instruction cycles later, read
  task automatic timed_count(input int k, input logic [7:0] e, input string tag);
    repeat (4*k+1) @(negedge clk);
    expect_rd(e, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_level(input logic v, input int n);
    ext_pin_i = v;
    idle(n);
  endtask

  task automatic wd_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wd_tick_i = 1'b1;
      @(negedge clk); wd_tick_i = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    idle(5);
    rst = 1'b0;

    // R1 reset state
    rd_check(2'd0, 8'h00, "R1 count");
    rd_check(2'd1, 8'h00, "R1 option");
    rd_check(2'd2, 8'h00, "R1 flag/enable");
    chk8({7'd0, irq_o}, 8'h00, "R1 irq");
    chk8({7'd0, wdt_tick_o}, 8'h00, "R1 wdt tick");

    // R2 R3 register access, done under sleep (R12)
    sleep_i = 1'b1;
    bus_wr(2'd0, 8'h5A);
    rd_check(2'd0, 8'h5A, "R2 count readback");
    bus_wr(2'd1, 8'hEC);
    rd_check(2'd1, 8'h2C, "R2 R3 option readback");
    bus_wr(2'd2, 8'h02);
    rd_check(2'd2, 8'h02, "R2 enable readback");
    chk8({7'd0, irq_o}, 8'h00, "R11 enable without flag");
    bus_wr(2'd2, 8'h00);

    // R12 no counting in sleep
    bus_wr(2'd1, 8'h04);
    bus_wr(2'd0, 8'h10);
    timed_count(10, 8'h10, "R12 sleep freeze");
    sleep_i = 1'b0;

    // R4 R5 timer rate and post-write hold
    bus_wr(2'd0, 8'h10);
    timed_count(7, 8'h15, "R4 R5 timer 1:1");
    bus_wr(2'd0, 8'h20);
    timed_count(2, 8'h20, "R5 two cycles swallowed");

    // R8 timer prescaler
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd0, 8'h00);
    timed_count(12, 8'h05, "R8 ratio 1:2");
    bus_wr(2'd1, 8'h08);
    bus_wr(2'd0, 8'h00);
    timed_count(18, 8'h04, "R8 ratio 1:4");

    // R10 R11 overflow
    bus_wr(2'd1, 8'h04);
    bus_wr(2'd2, 8'h00);
    bus_wr(2'd0, 8'hFE);
    timed_count(5, 8'h01, "R10 wrap value");
    rd_check(2'd2, 8'h01, "R10 flag set on wrap");
    chk8({7'd0, irq_o}, 8'h00, "R11 masked");
    bus_wr(2'd2, 8'h03);
    chk8({7'd0, irq_o}, 8'h01, "R11 enabled");
    idle(40);
    rd_check(2'd2, 8'h03, "R10 flag sticky");
    bus_wr(2'd2, 8'h02);
    chk8({7'd0, irq_o}, 8'h00, "R11 cleared");
    rd_check(2'd2, 8'h02, "R10 software clear");

    // R6 R7 R3 external, rising edge, 1:1
    bus_wr(2'd1, 8'h05);
    bus_wr(2'd0, 8'h00);
    idle(12);
    @(negedge clk); ext_pin_i = 1'b1;
    idle(3);
    expect_rd(8'h00, "R6 before sync");
    idle(1);
    expect_rd(8'h01, "R6 after sync");
    for (int i = 0; i < 4; i++) begin
      pin_level(1'b0, 4);
      pin_level(1'b1, 4);
    end
    idle(6);
    expect_rd(8'h05, "R7 rising count");

    // R7 falling edge
    bus_wr(2'd1, 8'h07);
    bus_wr(2'd0, 8'h00);
    idle(12);
    for (int i = 0; i < 4; i++) begin
      pin_level(1'b0, 4);
      pin_level(1'b1, 4);
    end
    pin_level(1'b0, 8);
    expect_rd(8'h05, "R7 falling count");

    // R8 prescaled external
    bus_wr(2'd1, 8'h09);
    bus_wr(2'd0, 8'h00);
    idle(12);
    for (int i = 0; i < 8; i++) begin
      pin_level(1'b1, 4);
      pin_level(1'b0, 4);
    end
    idle(4);
    expect_rd(8'h02, "R8 external 1:4");

    // R9 watchdog path
    bus_wr(2'd1, 8'h14);
    wdt_clr = 1'b1; idle(1); wdt_clr = 1'b0; wdt_cnt_en = 1'b1;
    wd_pulses(16);
    idle(4);
    wdt_cnt_en = 1'b0;
    chk8(8'(wdt_seen), 8'd4, "R9 watchdog 1:4");
    bus_wr(2'd1, 8'h00);
    wdt_clr = 1'b1; idle(1); wdt_clr = 1'b0; wdt_cnt_en = 1'b1;
    wd_pulses(16);
    idle(4);
    wdt_cnt_en = 1'b0;
    chk8(8'(wdt_seen), 8'd16, "R9 watchdog passthrough");

    idle(2);
    finish_run();
  end
endmodule